// File: doc/BRIEF.md
# Four-Instruction Accumulator Processor

This block is a small multicycle processor built around one 8-bit accumulator and a 6-bit program counter. It steps through a fixed sequence for every instruction. It fetches a byte from a 64-byte internal memory into an instruction register. It decodes that register. It then executes the instruction and goes back to fetch. Each instruction is one byte. The two top bits select the operation and the six low bits name a memory location directly.

There are four operations. Two combine a memory operand with the accumulator, by addition or by bitwise AND. One loads the program counter. One increments the accumulator and ignores its address field. Because a memory read takes one cycle, add and AND use an extra operand-read state, so they take four cycles; jump and increment take three. The program never writes memory. The memory is filled through a load port, and that port is honoured only while reset is held. The accumulator and program counter are brought out so the running program can be watched.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high (synchronous, active high), the accumulator, program counter and instruction register clear to 0 and the sequencer goes to fetch. In any clock cycle with `rst` and `loadEn` both high, `loadData` is written to memory at `loadAddr`. When `rst` is low, the load port has no effect and memory is never written.
- R2: An instruction byte holds the opcode in bits [7:6]: 00 is add, 01 is AND, 10 is jump, 11 is increment. Bits [5:0] hold a direct address `a`.
- R3: Add sets the accumulator to (accumulator + mem[a]) mod 256, with no carry kept. For example, byte 0x16 adds location 22.
- R4: AND sets the accumulator to the bitwise AND of the accumulator and mem[a].
- R5: Jump loads the program counter with `a`. This overrides the increment made during fetch.
- R6: Increment sets the accumulator to (accumulator + 1) mod 256. Address bits [5:0] have no effect.
- R7: Counting clock edges from fetch, jump and increment update their register on the third edge, and add and AND update the accumulator on the fourth edge. The accumulator is unchanged during the fetch and decode cycles.
- R8: The program counter increments by one during each fetch and wraps from 63 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; enables the load port |
| loadEn | input | 1 | Memory load strobe, honoured only during reset |
| loadAddr | input | 6 | Memory load address |
| loadData | input | 8 | Memory load byte |
| acc | output | 8 | Accumulator value |
| pc | output | 6 | Program counter value |

## Verification
The assertions check the following on every cycle:
- the reset clearing;
- that memory is never written outside reset;
- the fetch-decode ordering;
- that the accumulator holds still outside its update states;
- the program-counter step and wrap;
- the jump target load;
- the increment result.

The arithmetic results of add and AND against memory contents, the exact cycle on which results appear, and the load port being ignored during a run are shown only by the bench's directed programs. Those programs compare the final accumulator and program counter with values worked out by hand.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_AND = 2'b01,
    OP_JMP = 2'b10,
    OP_INC = 2'b11
  } opcode_t;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_OPRD   = 2'd3
  } cpu_state_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic irLoad;
    logic pcInc;
    logic pcJump;
    logic addrFromIr;
    logic accAdd;
    logic accAnd;
    logic accInc;
  } ctrl_t;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  opcode_t    op,
  output ctrl_t      ctl,
  output cpu_state_t state
);
  cpu_state_t stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_FETCH: begin
        ctl.pcInc = 1'b1;
        stateNext = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.irLoad = 1'b1;
        stateNext  = ST_EXEC;
      end
      ST_EXEC: begin
        unique case (op)
          OP_JMP: begin
            ctl.pcJump = 1'b1;
            stateNext  = ST_FETCH;
          end
          OP_INC: begin
            ctl.accInc = 1'b1;
            stateNext  = ST_FETCH;
          end
          default: begin
            ctl.addrFromIr = 1'b1;
            stateNext      = ST_OPRD;
          end
        endcase
      end
      ST_OPRD: begin
        ctl.accAdd = (op == OP_ADD);
        ctl.accAnd = (op == OP_AND);
        stateNext  = ST_FETCH;
      end
      default: stateNext = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctl,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output opcode_t           op,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir
);
  localparam int OP_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] irAddr;

  assign irAddr  = ir[ADDR_W-1:0];
  assign op      = opcode_t'(ir[DATA_W-1 -: OP_W]);
  assign memAddr = ctl.addrFromIr ? irAddr : pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ir  <= '0;
      acc <= '0;
    end else begin
      if (ctl.pcJump)     pc <= irAddr;
      else if (ctl.pcInc) pc <= pc + 1'b1;
      if (ctl.irLoad)     ir <= memRdata;
      if (ctl.accAdd)      acc <= acc + memRdata;
      else if (ctl.accAnd) acc <= acc & memRdata;
      else if (ctl.accInc) acc <= acc + 1'b1;
    end
  end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                loadEn,
  input  logic [ADDR_W-1:0]   loadAddr,
  input  logic [ADDR_W+1:0]   loadData,
  output logic [ADDR_W+1:0]   acc,
  output logic [ADDR_W-1:0]   pc
);
  localparam int DATA_W = ADDR_W + 2;

  ctrl_t             ctl;
  cpu_state_t        cpuState;
  opcode_t           op;
  logic [ADDR_W-1:0] cpuAddr;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memRdata;
  logic [DATA_W-1:0] ir;
  logic              memWe;

  // load port owns the memory only while reset is held
  assign memAddr = rst ? loadAddr : cpuAddr;
  assign memWe   = rst & loadEn;

  acc_cpu_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .addr(memAddr), .we(memWe), .wdata(loadData), .rdata(memRdata)
  );

  acc_cpu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .op(op), .ctl(ctl), .state(cpuState)
  );

  acc_cpu_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .memRdata(memRdata), .memAddr(cpuAddr),
    .op(op), .acc(acc), .pc(pc), .ir(ir)
  );
endmodule

// File: rtl/acc_cpu_checker.sv
module acc_cpu_checker
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                memWe,
  input cpu_state_t          cpuState,
  input logic [ADDR_W+1:0]   ir,
  input logic [ADDR_W+1:0]   acc,
  input logic [ADDR_W-1:0]   pc
);
  localparam int DATA_W = ADDR_W + 2;

  logic isExecJmp;
  logic isExecInc;
  assign isExecJmp = (cpuState == ST_EXEC) && (ir[DATA_W-1 -: 2] == 2'b10);
  assign isExecInc = (cpuState == ST_EXEC) && (ir[DATA_W-1 -: 2] == 2'b11);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (acc == '0 && pc == '0)); // R1
  AST_NO_RUN_WRITE: assert property (@(posedge clk) !rst |-> !memWe); // R1
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
    (cpuState == ST_FETCH) |=> (pc == ADDR_W'($past(pc) + 1'b1))); // R8
  AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (rst)
    (cpuState == ST_FETCH) |=> (cpuState == ST_DECODE)); // R7
  AST_ACC_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cpuState == ST_FETCH || cpuState == ST_DECODE) |=> $stable(acc)); // R7
  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (rst)
    isExecJmp |=> (pc == $past(ir[ADDR_W-1:0]))); // R5
  AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
    isExecInc |=> (acc == DATA_W'($past(acc) + 1'b1))); // R6
endmodule

bind acc_cpu_core acc_cpu_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rst(rst), .memWe(memWe), .cpuState(cpuState),
  .ir(ir), .acc(acc), .pc(pc)
);

// File: tb/acc_cpu_core_bench.sv
module acc_cpu_core_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       loadEn = 1'b0;
  logic [5:0] loadAddr = '0;
  logic [7:0] loadData = '0;
  logic [7:0] acc;
  logic [5:0] pc;

  int checks = 0;
  int errors = 0;
  logic [7:0] img [64];

  always #4 clk = ~clk;

  acc_cpu_core u_acc_cpu_core (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .acc(acc), .pc(pc)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic clearImg();
    for (int i = 0; i < 64; i++) img[i] = 8'h00;
  endtask

  // hold reset, write the whole image, release on a falling edge
  task automatic loadAndStart();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 64; i++) begin
      loadEn = 1'b1; loadAddr = 6'(i); loadData = img[i];
      @(negedge clk);
    end
    loadEn = 1'b0;
    check("R1 acc in reset", acc, 0);
    check("R1 pc in reset", pc, 0);
    rst = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testIncTiming();
    clearImg();
    img[0] = 8'hC0; img[1] = 8'h81;
    loadAndStart();
    edges(2); check("R7 inc not yet", acc, 0);
    edges(1); check("R7 R6 inc on third edge", acc, 1);
  endtask

  task automatic testAddTiming();
    clearImg();
    img[0] = 8'h14; img[1] = 8'h81; img[20] = 8'h07;
    loadAndStart();
    edges(3); check("R7 add not yet", acc, 0);
    edges(1); check("R7 add on fourth edge", acc, 7);
  endtask

  task automatic testAdd();
    clearImg();
    img[0] = 8'h16; img[1] = 8'h16; img[2] = 8'h82; img[22] = 8'h25;
    loadAndStart();
    edges(30); check("R3 add loc 22 twice", acc, 8'h4A);
  endtask

  task automatic testAnd();
    clearImg();
    img[0] = 8'h14; img[1] = 8'h55; img[2] = 8'h82;
    img[20] = 8'hF3; img[21] = 8'h3C;
    loadAndStart();
    edges(30); check("R4 and", acc, 8'h30);
  endtask

  task automatic testWrap();
    clearImg();
    img[0] = 8'h14; img[1] = 8'h14; img[2] = 8'h82; img[20] = 8'hC0;
    loadAndStart();
    edges(30); check("R3 add wraps mod 256", acc, 8'h80);
    clearImg();
    img[0] = 8'h14; img[1] = 8'hC0; img[2] = 8'h82; img[20] = 8'hFF;
    loadAndStart();
    edges(30); check("R6 inc wraps to zero", acc, 0);
  endtask

  task automatic testIncIgnoresField();
    clearImg();
    img[0] = 8'hFF; img[1] = 8'h81; img[63] = 8'h40;
    loadAndStart();
    edges(30); check("R6 R2 inc ignores low bits", acc, 1);
  endtask

  task automatic testJump();
    clearImg();
    img[0] = 8'h85; img[1] = 8'hC0; img[5] = 8'hC0; img[6] = 8'h86;
    loadAndStart();
    edges(3); check("R5 pc after jump", pc, 5);
    edges(40); check("R5 skipped code", acc, 1);
  endtask

  task automatic testPcWrap();
    clearImg();
    img[0] = 8'hBF; img[63] = 8'hC0;
    loadAndStart();
    edges(3); check("R5 pc jumped to 63", pc, 63);
    edges(1); check("R8 pc wraps 63 to 0", pc, 0);
    edges(2); check("R8 inc at 63 ran", acc, 1);
  endtask

  task automatic testLoadIgnored();
    clearImg();
    img[0] = 8'h80;
    loadAndStart();
    edges(3);
    @(negedge clk);
    loadEn = 1'b1; loadAddr = 6'd0; loadData = 8'hC0;
    repeat (5) @(negedge clk);
    loadEn = 1'b0;
    edges(20); check("R1 load ignored outside reset", acc, 0);
  endtask

  initial begin
    fork
      begin
        testIncTiming();
        testAddTiming();
        testAdd();
        testAnd();
        testWrap();
        testIncIgnoresField();
        testJump();
        testPcWrap();
        testLoadIgnored();
      end
      begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule